// File: doc/BRIEF.md
# Keystream Session Sequencer and Byte Packer

This controller runs one full keystream session through an external triple shift-register core. A single start pulse hands it a 64-bit session key and a 22-bit frame number. It then steps the core through a fixed schedule. First it loads the three registers from the key in one cycle. It then spends 22 steps folding the frame number into the state, least significant bit first. Next come 100 silent mixing steps and a first burst of 114 output bits. Another 100 silent steps follow, and the schedule ends with a second burst of 114 bits for the reverse direction.

The shift-register arithmetic lives in the core. This block only drives the load, step and inject strobes and takes back one keystream bit after each step. The core's bit is expected one cycle after the step that produced it. Each burst is packed into bytes, with the earliest bit in the most significant position. The bytes leave on a byte-wide valid interface. That interface has no ready signal, so the consumer must accept a byte in every cycle that valid is high. Each byte carries a direction flag and a flag marking the last byte of its burst. A one-cycle done pulse closes the session.

Top module: `ksg_session`

## Requirements
- R1: In the load cycle, the 19-bit register value is key bits 18:0, the 22-bit value is key bits 40:19 and the 23-bit value is key bits 63:41. The key is sampled on the accepted start, and key bit 0 is bit 0 of key byte 0.
- R2: A start seen while idle is accepted. Exactly one load cycle follows, in the next cycle, and no step is issued during it.
- R3: The 22 steps after the load cycle carry the inject strobe. The inject bit on the k-th of these steps (k from 0) equals frame bit k.
- R4: Two phases of 100 steps each produce no bytes. The first follows injection and the second separates the bursts.
- R5: Each burst takes 114 keystream bits and emits them as 15 bytes. Bits fill a byte from bit 7 downward, each new bit shifting in at bit 0, and a full byte is emitted after every 8 bits.
- R6: The 15th byte of a burst holds the burst's last two bits in bits 1:0, the earlier of them in bit 1, with zeros in bits 7:2. It is the only byte with the last flag set.
- R7: The direction flag is 0 on every byte of the first burst and 1 on every byte of the second.
- R8: A session issues 450 steps, one in every cycle from the first step to the last without a gap.
- R9: A start raised while a session is busy is ignored: no second load occurs and the running session's bytes are unchanged.
- R10: Done is high for exactly one cycle, the cycle right after the last byte of the second burst.
- R11: During and after reset, busy, done, byte valid, load and step are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start request, taken only while idle |
| key_i | input | 64 | Session key, bit 0 = bit 0 of byte 0 |
| frame_i | input | 22 | Frame number |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| core_load_o | output | 1 | Load strobe to the core |
| core_r1_o | output | 19 | Load value, short register |
| core_r2_o | output | 22 | Load value, middle register |
| core_r3_o | output | 23 | Load value, long register |
| core_step_o | output | 1 | Step strobe to the core |
| core_inject_o | output | 1 | Frame-injection qualifier for this step |
| core_inj_bit_o | output | 1 | Frame bit to inject this step |
| core_bit_i | input | 1 | Keystream bit from the core, valid the cycle after a step |
| byte_valid_o | output | 1 | Packed byte present (no back-pressure) |
| byte_data_o | output | 8 | Packed keystream byte |
| byte_dir_o | output | 1 | 0 = first burst, 1 = second burst |
| byte_last_o | output | 1 | Final (partial) byte of a burst |

## Verification
The bench builds the block with its default parameters: a 22-bit frame, 100 mixing steps and 114-bit bursts. These put the real phase boundaries in reach, including the two-bit tail byte at the end of each burst and the exact 450-step count. A stand-in core in the bench returns a chosen pattern of bits keyed to the step index, so every expected byte can be worked out from the schedule alone. Patterns of all ones expose the zero fill above the two-bit tail. A start raised mid-session and a reset taken mid-burst test that the schedule cannot be restarted and that it recovers cleanly.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_INJ,
    PH_MIX1,
    PH_OUT1,
    PH_MIX2,
    PH_OUT2,
    PH_TAIL
  } ksg_phase_e;
endpackage

// File: rtl/ksg_keymap.sv
// Captures the session key on an accepted start and slices it into
// the three register load values.
module ksg_keymap #(
  parameter int W1 = 19,
  parameter int W2 = 22,
  parameter int W3 = 23,
  localparam int KW = W1 + W2 + W3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [KW-1:0] key_i,
  output logic [W1-1:0] r1_o,
  output logic [W2-1:0] r2_o,
  output logic [W3-1:0] r3_o
);
  logic [KW-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (accept_i) key_q <= key_i;
  end

  assign r1_o = key_q[W1-1:0];
  assign r2_o = key_q[W1+W2-1:W1];
  assign r3_o = key_q[KW-1:W1+W2];
endmodule

// File: rtl/ksg_sched.sv
// Phase schedule: one load cycle, then a step in every cycle through
// injection, mixing and both bursts, then a short tail for the packer.
module ksg_sched
  import ksg_pkg::*;
#(
  parameter int FRAME_W = 22,
  parameter int MIX_N   = 100,
  parameter int BURST_N = 114,
  localparam int TAIL_N = 3,
  localparam int MAX_A  = (FRAME_W > MIX_N) ? FRAME_W : MIX_N,
  localparam int MAX_N  = (MAX_A > BURST_N) ? MAX_A : BURST_N,
  localparam int CNT_W  = $clog2(MAX_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               accept_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               load_o,
  output logic               step_o,
  output logic               inject_o,
  output logic               inj_bit_o,
  output logic               take_o,
  output logic               take_last_o,
  output logic               dir_o
);
  ksg_phase_e         phase_q, phase_nx;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   len_m1;
  logic [FRAME_W-1:0] frame_q;
  logic               at_end;

  always_comb begin
    case (phase_q)
      PH_INJ:           len_m1 = CNT_W'(FRAME_W - 1);
      PH_MIX1, PH_MIX2: len_m1 = CNT_W'(MIX_N - 1);
      PH_OUT1, PH_OUT2: len_m1 = CNT_W'(BURST_N - 1);
      PH_TAIL:          len_m1 = CNT_W'(TAIL_N - 1);
      default:          len_m1 = '0;
    endcase
  end

  assign at_end   = (cnt_q == len_m1);
  assign accept_o = start_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_nx = phase_q;
    case (phase_q)
      PH_IDLE: if (start_i) phase_nx = PH_LOAD;
      PH_LOAD: phase_nx = PH_INJ;
      PH_INJ:  if (at_end) phase_nx = PH_MIX1;
      PH_MIX1: if (at_end) phase_nx = PH_OUT1;
      PH_OUT1: if (at_end) phase_nx = PH_MIX2;
      PH_MIX2: if (at_end) phase_nx = PH_OUT2;
      PH_OUT2: if (at_end) phase_nx = PH_TAIL;
      PH_TAIL: if (at_end) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      frame_q <= '0;
    end else begin
      phase_q <= phase_nx;
      if (phase_nx != phase_q) cnt_q <= '0;
      else if (phase_q != PH_IDLE) cnt_q <= cnt_q + 1'b1;
      if (accept_o)              frame_q <= frame_i;
      else if (phase_q == PH_INJ) frame_q <= frame_q >> 1;
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign load_o      = (phase_q == PH_LOAD);
  assign inject_o    = (phase_q == PH_INJ);
  assign inj_bit_o   = inject_o && frame_q[0];
  assign take_o      = (phase_q == PH_OUT1) || (phase_q == PH_OUT2);
  assign step_o      = inject_o || take_o ||
                       (phase_q == PH_MIX1) || (phase_q == PH_MIX2);
  assign take_last_o = take_o && at_end;
  assign dir_o       = (phase_q == PH_OUT2);
  assign done_o      = (phase_q == PH_TAIL) && at_end;
endmodule

// File: rtl/ksg_packer.sv
// Collects the core's bit one cycle after each burst step, MSB first,
// and emits a byte on every eighth bit or on the last bit of a burst.
module ksg_packer #(
  parameter int BYTE_W = 8,
  localparam int BC_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              dir_i,
  input  logic              bit_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              dir_o,
  output logic              last_o
);
  logic              take_q, last_q, dir_q;
  logic [BYTE_W-1:0] acc_q, acc_nx;
  logic [BC_W-1:0]   bc_q;
  logic              emit;

  assign acc_nx = {acc_q[BYTE_W-2:0], bit_i};
  assign emit   = take_q && ((bc_q == BC_W'(BYTE_W - 1)) || last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
      acc_q   <= '0;
      bc_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      dir_o   <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      take_q  <= take_i;
      last_q  <= last_i;
      dir_q   <= dir_i;
      valid_o <= emit;
      if (emit) begin
        data_o <= acc_nx;
        dir_o  <= dir_q;
        last_o <= last_q;
        acc_q  <= '0;
        bc_q   <= '0;
      end else if (take_q) begin
        acc_q <= acc_nx;
        bc_q  <= bc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ksg_session.sv
module ksg_session #(
  parameter int W1      = 19,
  parameter int W2      = 22,
  parameter int W3      = 23,
  parameter int FRAME_W = 22,
  parameter int MIX_N   = 100,
  parameter int BURST_N = 114,
  localparam int KW     = W1 + W2 + W3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [KW-1:0]      key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               core_load_o,
  output logic [W1-1:0]      core_r1_o,
  output logic [W2-1:0]      core_r2_o,
  output logic [W3-1:0]      core_r3_o,
  output logic               core_step_o,
  output logic               core_inject_o,
  output logic               core_inj_bit_o,
  input  logic               core_bit_i,
  output logic               byte_valid_o,
  output logic [7:0]         byte_data_o,
  output logic               byte_dir_o,
  output logic               byte_last_o
);
  logic accept, take, take_last, dir;

  ksg_sched #(
    .FRAME_W(FRAME_W), .MIX_N(MIX_N), .BURST_N(BURST_N)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .accept_o(accept), .busy_o(busy_o), .done_o(done_o),
    .load_o(core_load_o), .step_o(core_step_o),
    .inject_o(core_inject_o), .inj_bit_o(core_inj_bit_o),
    .take_o(take), .take_last_o(take_last), .dir_o(dir)
  );

  ksg_keymap #(.W1(W1), .W2(W2), .W3(W3)) u_keymap (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .key_i(key_i),
    .r1_o(core_r1_o), .r2_o(core_r2_o), .r3_o(core_r3_o)
  );

  ksg_packer #(.BYTE_W(8)) u_packer (
    .clk(clk), .rst_n(rst_n), .take_i(take), .last_i(take_last),
    .dir_i(dir), .bit_i(core_bit_i), .valid_o(byte_valid_o),
    .data_o(byte_data_o), .dir_o(byte_dir_o), .last_o(byte_last_o)
  );
endmodule

// File: rtl/ksg_session_chk.sv
module ksg_session_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic core_load_o,
  input logic core_step_o,
  input logic core_inject_o,
  input logic byte_valid_o,
  input logic byte_dir_o,
  input logic byte_last_o
);
  a_r2_load_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    core_load_o |-> $past(start_i && !busy_o));

  a_r2_no_step_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_load_o, core_step_o}));

  a_r3_inject_is_step: assert property (@(posedge clk) disable iff (!rst_n)
    core_inject_o |-> core_step_o);

  a_r9_load_once: assert property (@(posedge clk) disable iff (!rst_n)
    core_load_o |=> !core_load_o);

  a_r4_bytes_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> busy_o);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(byte_valid_o && byte_last_o && byte_dir_o));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(busy_o || done_o || byte_valid_o || core_load_o || core_step_o));
endmodule

bind ksg_session ksg_session_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .core_load_o(core_load_o), .core_step_o(core_step_o),
  .core_inject_o(core_inject_o), .byte_valid_o(byte_valid_o),
  .byte_dir_o(byte_dir_o), .byte_last_o(byte_last_o)
);

// File: tb/ksg_session_bench.sv
module ksg_session_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam int FIRST_OUT1 = 123;  // step index of the first burst bit
  localparam int FIRST_OUT2 = 337;  // 123 + 114 + 100

  // key, frame, pattern seed, invert, mid-session start
  localparam logic [103:0] VEC [NVEC] = '{
    {64'h0123_4567_89AB_CDEF, 22'h2A_5A5A, 16'h9E37, 1'b0, 1'b0},
    {64'hFFFF_0000_DEAD_BEEF, 22'h00_0001, 16'h0000, 1'b1, 1'b1},
    {64'h8000_0000_0000_0001, 22'h20_0000, 16'h0000, 1'b0, 1'b0},
    {64'h5A5A_C3C3_0F0F_7E81, 22'h3F_FFFF, 16'h3B1D, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] key_i = '0;
  logic [21:0] frame_i = '0;
  logic        busy_o, done_o, core_load_o, core_step_o;
  logic        core_inject_o, core_inj_bit_o, byte_valid_o;
  logic        byte_dir_o, byte_last_o;
  logic [18:0] core_r1_o;
  logic [21:0] core_r2_o;
  logic [22:0] core_r3_o;
  logic [7:0]  byte_data_o;
  logic        core_bit_i;

  int n_chk = 0, n_fail = 0;

  ksg_session u_ksg_session (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic pat(int n, logic [15:0] seed, logic inv);
    logic [31:0] p;
    p = n * seed;
    return (^p[15:0]) ^ inv;
  endfunction

  function automatic logic [7:0] exp_byte(int d, int j, logic [15:0] seed, logic inv);
    logic [7:0] v;
    int base, hi;
    base = d ? FIRST_OUT2 : FIRST_OUT1;
    hi = (8*j + 7 > 113) ? 113 : 8*j + 7;
    v = '0;
    for (int i = 8*j; i <= hi; i++) v = {v[6:0], pat(base + i, seed, inv)};
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // session context
  logic        sess_clr = 1'b0;
  logic [63:0] cur_key;
  logic [21:0] cur_frame;
  logic [15:0] cur_seed;
  logic        cur_inv;

  // stand-in core: bit for step n appears the cycle after the step
  int   step_n;
  logic fbit;
  always @(posedge clk) begin
    if (sess_clr) begin
      step_n <= 0;
      fbit   <= 1'b0;
    end else if (core_step_o) begin
      step_n <= step_n + 1;
      fbit   <= pat(step_n + 1, cur_seed, cur_inv);
    end
  end
  assign core_bit_i = fbit;

  // monitor, sampled on the falling edge
  int cyc, loads, steps, inj_n, nbytes, dones, last_byte_cyc, first_step, last_step;
  always @(negedge clk) begin
    if (sess_clr) begin
      cyc = 0; loads = 0; steps = 0; inj_n = 0; nbytes = 0; dones = 0;
      last_byte_cyc = -10; first_step = -1; last_step = -1;
    end else if (rst_n) begin
      cyc++;
      if (core_load_o) begin
        loads++;
        check(core_r1_o == cur_key[18:0],  "R1 r1", 64'(core_r1_o), 64'(cur_key[18:0]));
        check(core_r2_o == cur_key[40:19], "R1 r2", 64'(core_r2_o), 64'(cur_key[40:19]));
        check(core_r3_o == cur_key[63:41], "R1 r3", 64'(core_r3_o), 64'(cur_key[63:41]));
      end
      if (core_step_o) begin
        steps++;
        if (first_step < 0) first_step = cyc;
        last_step = cyc;
      end
      if (core_inject_o) begin
        check(inj_n < 22 && core_inj_bit_o == cur_frame[inj_n % 22], "R3 inject bit",
              64'(core_inj_bit_o), 64'(cur_frame[inj_n % 22]));
        inj_n++;
      end
      if (byte_valid_o) begin
        int d, j;
        d = nbytes / 15;
        j = nbytes % 15;
        check(byte_data_o == exp_byte(d, j, cur_seed, cur_inv),
              (j == 14) ? "R6 tail byte" : "R5 byte data",
              64'(byte_data_o), 64'(exp_byte(d, j, cur_seed, cur_inv)));
        check(byte_dir_o == d[0], "R7 dir", 64'(byte_dir_o), 64'(d[0]));
        check(byte_last_o == (j == 14), "R6 last flag", 64'(byte_last_o), 64'(j == 14));
        nbytes++;
        last_byte_cyc = cyc;
      end
      if (done_o) begin
        dones++;
        check(last_byte_cyc == cyc - 1 && nbytes == 30, "R10 done timing",
              64'(cyc - last_byte_cyc), 64'd1);
      end
    end
  end

  task automatic clear_session(input logic [103:0] v);
    cur_key = v[103:40]; cur_frame = v[39:18]; cur_seed = v[17:2]; cur_inv = v[1];
    @(negedge clk); sess_clr = 1'b1;
    @(negedge clk); sess_clr = 1'b0;
  endtask

  task automatic run_session(input logic [103:0] v);
    clear_session(v);
    key_i = v[103:40]; frame_i = v[39:18]; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    key_i = ~key_i; frame_i = ~frame_i;
    if (v[0]) begin
      repeat (60) @(negedge clk);
      check(busy_o == 1'b1, "R9 busy mid-session", 64'(busy_o), 64'd1);
      start_i = 1'b1;  // must be ignored
      @(negedge clk); start_i = 1'b0;
    end
    for (int t = 0; t < 1000 && dones == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(loads == 1, "R2/R9 single load", 64'(loads), 64'd1);
    check(inj_n == 22, "R3 inject count", 64'(inj_n), 64'd22);
    check(steps == 450, "R8 step count", 64'(steps), 64'd450);
    check(last_step - first_step == 449, "R8 gapless steps",
          64'(last_step - first_step), 64'd449);
    check(nbytes == 30, "R4/R5 byte count", 64'(nbytes), 64'd30);
    check(dones == 1, "R10 done count", 64'(dones), 64'd1);
    check(busy_o == 1'b0, "R10 idle after done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    cur_key = '0; cur_frame = '0; cur_seed = '0; cur_inv = 1'b0;
    start_i = 1'b1;  // R11: start during reset has no effect
    repeat (3) @(negedge clk);
    check({busy_o, done_o, byte_valid_o, core_load_o, core_step_o} == 5'b0,
          "R11 reset state", 64'({busy_o, done_o, byte_valid_o, core_load_o, core_step_o}), 64'd0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R11 idle after reset", 64'(busy_o), 64'd0);

    for (int k = 0; k < NVEC; k++) run_session(VEC[k]);

    // R11: reset in the middle of the first burst
    clear_session(VEC[0]);
    key_i = VEC[0][103:40]; frame_i = VEC[0][39:18]; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int t = 0; t < 1000 && nbytes < 3; t++) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({busy_o, done_o, byte_valid_o, core_load_o, core_step_o} == 5'b0,
          "R11 mid-session reset", 64'({busy_o, done_o, byte_valid_o, core_load_o, core_step_o}), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy_o == 1'b0, "R11 stays idle", 64'(busy_o), 64'd0);
    run_session(VEC[3]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule